// File: doc/BRIEF.md
# Serial Receiver with Sleep and Wake-Up

This block recovers asynchronous serial characters from a single input line. Each character is a low start bit, 8 or 9 data bits sent least significant bit first, and one high stop bit. A 16x oversampling tick paces all timing. A finished character goes to a holding register with a data-full flag. An overrun flag records a character that arrived while the holding register was still full. An idle flag reports a quiet line after traffic. Each flag has a gated interrupt request.

For multi-drop buses the host can put the receiver to sleep. While asleep, the receiver raises no interrupt and ignores characters that are not meant for this node. A control bit picks the wake event. The first choice is a full character time of idle line. The second is an address character whose most significant data bit is 1. The hardware clears the sleep state by itself when the chosen event occurs.

Top module: `uart_wake_rx`

## Requirements
- R1: A character is a start bit, then 8 data bits (`nine_bits`=0) or 9 data bits (`nine_bits`=1), least significant first, then a stop bit. `rx_data` shows the bits in place, with bit 8 = 0 in 8-bit mode.
- R2: After reset, all flags, `sleeping` and `irq` are 0. While `rx_en` is 0, the line is ignored and no flag is set.
- R3: A character with a high stop bit sets `rx_full` and loads `rx_data`. A character with a low stop bit is discarded.
- R4: A character that completes while `rx_full` is 1 sets `overrun` and is discarded. `rx_data` keeps the earlier character.
- R5: A one-cycle `rd_strobe` clears `rx_full`, `overrun` and `idle_seen`.
- R6: `idle_seen` sets after one character time of continuous high line: 10 bit times for 8-bit characters, 11 for 9-bit. At least one character must have been accepted since the last idle report. It sets only once per idle period.
- R7: `irq` = !`sleeping` & ((`rx_int_en` & (`rx_full` | `overrun`)) | (`idle_int_en` & `idle_seen`)).
- R8: A `sleep_req` pulse sets `sleeping`. While asleep, `irq` is 0, and a character that does not wake the receiver changes no flag.
- R9: With `wake_on_addr`=1, a character whose most significant data bit is 1 (bit 7 in 8-bit mode, bit 8 in 9-bit mode) clears `sleeping`. That character is accepted normally.
- R10: With `wake_on_addr`=0, a new idle period of one character time clears `sleeping`. That idle period does not set `idle_seen`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | Oversampling enable, 16 per bit time |
| rx_line | input | 1 | Serial input, idles high |
| rx_en | input | 1 | Receiver enable |
| nine_bits | input | 1 | 1 selects 9 data bits |
| wake_on_addr | input | 1 | 1 = wake on address mark, 0 = wake on idle line |
| sleep_req | input | 1 | Pulse that puts the receiver to sleep |
| rx_int_en | input | 1 | Interrupt enable for data-full and overrun |
| idle_int_en | input | 1 | Interrupt enable for idle line |
| rd_strobe | input | 1 | Data register read pulse |
| rx_data | output | 9 | Received character |
| rx_full | output | 1 | Receive data full flag |
| overrun | output | 1 | Overrun flag |
| idle_seen | output | 1 | Idle line flag |
| sleeping | output | 1 | Receiver is in sleep mode |
| irq | output | 1 | Interrupt request |

## Verification
With a tick every clock, a bit lasts 16 cycles. The line passes a two-flop synchronizer. The stop bit is sampled 8 ticks into its period, so `rx_full`, `overrun` and a wake by address mark appear about 11 cycles after the stop bit begins. The bench therefore samples them two cycles after the whole stop bit has been driven. The idle flag and the idle wake are due about 160 (8-bit) or 176 (9-bit) cycles after the stop-bit centre. The bench checks them as absent 100 cycles into the quiet line and as present after 200. A read clears the flags one cycle after the strobe, and a sleep request drops `irq` one cycle after the request. All samples are taken on the falling clock edge.

// File: rtl/uwr_pkg.sv
package uwr_pkg;
  typedef enum logic [1:0] {
    FR_IDLE  = 2'd0,
    FR_START = 2'd1,
    FR_DATA  = 2'd2,
    FR_STOP  = 2'd3
  } fr_state_t;
endpackage

// File: rtl/uwr_sync.sv
module uwr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe <= '1;
    else        pipe <= {pipe[STAGES-2:0], d};
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/uwr_frame.sv
module uwr_frame
  import uwr_pkg::*;
#(
  parameter int OVS    = 16,
  parameter int DMAX   = 9,
  localparam int CW    = $clog2(OVS),
  localparam int BW    = $clog2(DMAX + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            tick,
  input  logic            rx,
  input  logic            nine,
  output logic            busy,
  output logic            done,
  output logic [DMAX-1:0] data
);
  localparam logic [CW-1:0] MID  = CW'(OVS / 2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OVS - 1);

  fr_state_t       st, st_n;
  logic [CW-1:0]   cnt, cnt_n;
  logic [BW-1:0]   bidx, bidx_n;
  logic [DMAX-1:0] sr, sr_n;
  logic [BW-1:0]   nbits;

  assign nbits = nine ? BW'(DMAX) : BW'(DMAX - 1);

  always_comb begin
    st_n   = st;
    cnt_n  = cnt;
    bidx_n = bidx;
    sr_n   = sr;
    done   = 1'b0;
    if (!en) begin
      st_n  = FR_IDLE;
      cnt_n = '0;
    end else if (tick) begin
      unique case (st)
        FR_IDLE: if (!rx) begin
          st_n  = FR_START;
          cnt_n = CW'(1);
        end
        FR_START: begin
          if (cnt == MID) begin
            cnt_n  = '0;
            bidx_n = '0;
            st_n   = rx ? FR_IDLE : FR_DATA;
          end else cnt_n = cnt + CW'(1);
        end
        FR_DATA: begin
          if (cnt == LAST) begin
            cnt_n  = '0;
            sr_n   = {rx, sr[DMAX-1:1]};
            bidx_n = bidx + BW'(1);
            if (bidx == nbits - BW'(1)) st_n = FR_STOP;
          end else cnt_n = cnt + CW'(1);
        end
        FR_STOP: begin
          if (cnt == LAST) begin
            cnt_n = '0;
            st_n  = FR_IDLE;
            done  = rx;
          end else cnt_n = cnt + CW'(1);
        end
        default: st_n = FR_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= FR_IDLE;
      cnt  <= '0;
      bidx <= '0;
      sr   <= '0;
    end else begin
      st   <= st_n;
      cnt  <= cnt_n;
      bidx <= bidx_n;
      sr   <= sr_n;
    end
  end

  assign busy = (st != FR_IDLE);
  assign data = nine ? sr : {1'b0, sr[DMAX-1:1]};
endmodule

// File: rtl/uwr_idle.sv
module uwr_idle #(
  parameter int OVS  = 16,
  parameter int DMAX = 9,
  localparam int THR9 = (DMAX + 2) * OVS,
  localparam int THR8 = (DMAX + 1) * OVS,
  localparam int IW   = $clog2(THR9 + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic tick,
  input  logic rx,
  input  logic busy,
  input  logic nine,
  output logic evt
);
  logic [IW-1:0] cnt, cnt_n;
  logic [IW-1:0] thr;

  assign thr = nine ? IW'(THR9) : IW'(THR8);

  always_comb begin
    cnt_n = cnt;
    evt   = 1'b0;
    if (!en || busy || !rx) begin
      cnt_n = '0;
    end else if (tick && cnt < thr) begin
      cnt_n = cnt + IW'(1);
      evt   = (cnt == thr - IW'(1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_n;
  end
endmodule

// File: rtl/uart_wake_rx.sv
module uart_wake_rx #(
  parameter int OVS  = 16,
  parameter int DMAX = 9
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick16,
  input  logic            rx_line,
  input  logic            rx_en,
  input  logic            nine_bits,
  input  logic            wake_on_addr,
  input  logic            sleep_req,
  input  logic            rx_int_en,
  input  logic            idle_int_en,
  input  logic            rd_strobe,
  output logic [DMAX-1:0] rx_data,
  output logic            rx_full,
  output logic            overrun,
  output logic            idle_seen,
  output logic            sleeping,
  output logic            irq
);
  logic            rx_s, busy, frame_done, idle_evt, addr_mark;
  logic [DMAX-1:0] frame_data;
  logic            accept, wake;
  logic            full_n, ovr_n, idle_n, sleep_n, armed, armed_n;
  logic            load;

  uwr_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(rx_line), .q(rx_s)
  );

  uwr_frame #(.OVS(OVS), .DMAX(DMAX)) u_frame (
    .clk(clk), .rst_n(rst_n), .en(rx_en), .tick(tick16), .rx(rx_s),
    .nine(nine_bits), .busy(busy), .done(frame_done), .data(frame_data)
  );

  uwr_idle #(.OVS(OVS), .DMAX(DMAX)) u_idle (
    .clk(clk), .rst_n(rst_n), .en(rx_en), .tick(tick16), .rx(rx_s),
    .busy(busy), .nine(nine_bits), .evt(idle_evt)
  );

  assign addr_mark = nine_bits ? frame_data[DMAX-1] : frame_data[DMAX-2];
  assign wake      = sleeping && (wake_on_addr ? (frame_done && addr_mark) : idle_evt);
  assign accept    = frame_done && (!sleeping || (wake_on_addr && addr_mark));
  assign load      = accept && !(rx_full && !rd_strobe);

  always_comb begin
    full_n  = rx_full;
    ovr_n   = overrun;
    idle_n  = idle_seen;
    armed_n = armed;
    sleep_n = sleeping;
    if (rd_strobe) begin
      full_n = 1'b0;
      ovr_n  = 1'b0;
      idle_n = 1'b0;
    end
    if (accept) begin
      full_n  = 1'b1;
      armed_n = 1'b1;
      if (rx_full && !rd_strobe) ovr_n = 1'b1;
    end
    if (idle_evt && armed && !sleeping) begin
      idle_n  = 1'b1;
      armed_n = 1'b0;
    end
    if (wake)      sleep_n = 1'b0;
    if (sleep_req) sleep_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_full   <= 1'b0;
      overrun   <= 1'b0;
      idle_seen <= 1'b0;
      armed     <= 1'b0;
      sleeping  <= 1'b0;
    end else begin
      rx_full   <= full_n;
      overrun   <= ovr_n;
      idle_seen <= idle_n;
      armed     <= armed_n;
      sleeping  <= sleep_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    rx_data <= '0;
    else if (load) rx_data <= frame_data;
  end

  assign irq = !sleeping && ((rx_int_en && (rx_full || overrun)) ||
                             (idle_int_en && idle_seen));
endmodule

// File: rtl/uart_wake_rx_chk.sv
module uart_wake_rx_chk (
  input logic clk,
  input logic rst_n,
  input logic rx_en,
  input logic sleep_req,
  input logic rd_strobe,
  input logic frame_done,
  input logic rx_full,
  input logic overrun,
  input logic idle_seen,
  input logic sleeping,
  input logic irq
);
  a_r8_quiet_asleep: assert property (@(posedge clk) disable iff (!rst_n)
    sleeping |-> !irq);

  a_r4_overrun_implies_full: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |-> rx_full);

  a_r5_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && !frame_done) |=> (!rx_full && !overrun && !idle_seen));

  a_r3_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_full && !rd_strobe) |=> rx_full);

  a_r2_disabled_no_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_en && !rx_full) |=> !rx_full);

  a_r8_sleep_entry: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_req |=> sleeping);
endmodule

bind uart_wake_rx uart_wake_rx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .sleep_req(sleep_req),
  .rd_strobe(rd_strobe), .frame_done(frame_done), .rx_full(rx_full),
  .overrun(overrun), .idle_seen(idle_seen), .sleeping(sleeping), .irq(irq)
);

// File: tb/uart_wake_rx_test.sv
`timescale 1ns/1ps
module uart_wake_rx_test;
  logic clk, rst_n, tick16, rx_line, rx_en, nine_bits, wake_on_addr;
  logic sleep_req, rx_int_en, idle_int_en, rd_strobe;
  logic [8:0] rx_data;
  logic rx_full, overrun, idle_seen, sleeping, irq;
  int checks, errors;
  bit done_flag;

  uart_wake_rx uut (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .rx_line(rx_line), .rx_en(rx_en),
    .nine_bits(nine_bits), .wake_on_addr(wake_on_addr), .sleep_req(sleep_req),
    .rx_int_en(rx_int_en), .idle_int_en(idle_int_en), .rd_strobe(rd_strobe),
    .rx_data(rx_data), .rx_full(rx_full), .overrun(overrun), .idle_seen(idle_seen),
    .sleeping(sleeping), .irq(irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input int val, input int nb, input bit stopb);
    rx_line = 1'b0; cyc(16);
    for (int i = 0; i < nb; i++) begin rx_line = val[i]; cyc(16); end
    rx_line = stopb; cyc(16);
    rx_line = 1'b1; cyc(2);
  endtask

  task automatic rd();
    rd_strobe = 1'b1; cyc(1); rd_strobe = 1'b0;
  endtask

  function automatic bit exp_irq();
    return !sleeping && ((rx_int_en && (rx_full || overrun)) || (idle_int_en && idle_seen));
  endfunction

  initial begin
    cyc(150000);
    checks++; errors++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    checks = 0; errors = 0;
    rst_n = 1'b0; tick16 = 1'b1; rx_line = 1'b1; rx_en = 1'b0; nine_bits = 1'b0;
    wake_on_addr = 1'b0; sleep_req = 1'b0; rx_int_en = 1'b0; idle_int_en = 1'b0;
    rd_strobe = 1'b0;
    cyc(3); rst_n = 1'b1; cyc(2);
    // R2 reset state
    check({rx_full, overrun, idle_seen, sleeping, irq} == 5'b0, "R2 reset", {rx_full, overrun, idle_seen, sleeping, irq}, 0);
    // R2 disabled receiver ignores line
    send(8'h3C, 8, 1'b1); cyc(200);
    check(!rx_full && !idle_seen, "R2 disabled", rx_full, 0);
    rx_en = 1'b1; rx_int_en = 1'b1; cyc(20);
    // R1 R3 R7 sweep of 8-bit characters
    for (int v = 0; v < 256; v += 15) begin
      send(v, 8, 1'b1);
      check(rx_full, "R3 full", rx_full, 1);
      check(rx_data == 9'(v), "R1 data8", rx_data, v);
      check(irq == 1'b1, "R7 irq full", irq, 1);
      rd(); cyc(1);
      check(!rx_full && !irq, "R5 read clears", rx_full, 0);
    end
    // R6 idle after one character time, and once only
    cyc(100);
    check(!idle_seen, "R6 idle early", idle_seen, 0);
    cyc(100);
    check(idle_seen, "R6 idle set", idle_seen, 1);
    check(irq == 1'b0, "R7 idle masked", irq, 0);
    idle_int_en = 1'b1; cyc(1);
    check(irq == 1'b1, "R7 idle irq", irq, 1);
    rd(); cyc(1);
    check(!idle_seen, "R5 idle read", idle_seen, 0);
    cyc(400);
    check(!idle_seen, "R6 once per period", idle_seen, 0);
    // R3 bad stop bit discarded
    send(8'h55, 8, 1'b0); cyc(20);
    check(!rx_full, "R3 bad stop", rx_full, 0);
    // R1 nine-bit sweep
    nine_bits = 1'b1; cyc(200); rd(); idle_int_en = 1'b0;
    for (int v = 0; v < 512; v += 37) begin
      send(v, 9, 1'b1);
      check(rx_full && rx_data == 9'(v), "R1 data9", rx_data, v);
      rd();
    end
    nine_bits = 1'b0;
    cyc(300); rd();
    // R4 overrun
    send(8'hA5, 8, 1'b1);
    send(8'h5A, 8, 1'b1);
    check(overrun && rx_full, "R4 overrun", overrun, 1);
    check(rx_data == 9'h0A5, "R4 keep old", rx_data, 9'h0A5);
    check(irq == exp_irq() && irq, "R7 overrun irq", irq, 1);
    rd(); cyc(1);
    check(!overrun && !rx_full, "R5 clears overrun", overrun, 0);
    // R8 sleep inhibits irq, address-mark wake R9
    send(8'h11, 8, 1'b1);
    wake_on_addr = 1'b1;
    sleep_req = 1'b1; cyc(1); sleep_req = 1'b0;
    check(sleeping && !irq, "R8 irq inhibited", irq, 0);
    rd();
    send(8'h05, 8, 1'b1);
    check(sleeping && !rx_full, "R8 non-wake ignored", rx_full, 0);
    send(8'h85, 8, 1'b1);
    check(!sleeping, "R9 addr wake", sleeping, 0);
    check(rx_full && rx_data == 9'h085, "R9 addr accepted", rx_data, 9'h085);
    rd();
    // R9 nine-bit address mark in bit 8
    nine_bits = 1'b1;
    sleep_req = 1'b1; cyc(1); sleep_req = 1'b0;
    send(9'h0FF, 9, 1'b1);
    check(sleeping && !rx_full, "R9 bit7 not mark", sleeping, 1);
    send(9'h101, 9, 1'b1);
    check(!sleeping && rx_data == 9'h101, "R9 nine mark", rx_data, 9'h101);
    rd(); nine_bits = 1'b0; cyc(300); rd();
    // R10 idle-line wake
    wake_on_addr = 1'b0;
    sleep_req = 1'b1; cyc(1); sleep_req = 1'b0;
    send(8'h80, 8, 1'b1);
    check(sleeping && !rx_full, "R10 frame while asleep", rx_full, 0);
    cyc(100);
    check(sleeping, "R10 not yet awake", sleeping, 1);
    cyc(100);
    check(!sleeping, "R10 idle wake", sleeping, 0);
    check(!idle_seen, "R10 no idle flag", idle_seen, 0);
    send(8'h42, 8, 1'b1);
    check(rx_full && rx_data == 9'h042, "R10 receive after wake", rx_data, 9'h042);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule